// File: doc/BRIEF.md
# Mode-Selected Clock Divider Tree

This block turns one fast core clock into three related clock outputs: a processor clock, a bus clock at a fixed ratio below it, and an interrupt-controller clock at half the bus rate. A 3-bit frequency-select code chooses the ratio and the operating mode. The core clock is assumed to run at twice the wanted processor rate, so the processor clock is always core/2. The bus clock is processor/2 when the top select bit is 0 and processor/3 when it is 1. The interrupt-controller clock is bus/2.

The select code also picks the mode. Code 000 floats every driver. Codes 011 and 111 are the normal running modes. Code 100 is a test mode: the dividers count rising edges of an external test clock instead of core cycles, and a steering output tells the reference driver to pass that test clock straight through. The remaining codes are reserved: the core clock drivers are switched off while the auxiliary drivers stay on.

All three outputs come from one shared phase counter, so their rising edges line up. A new select code takes effect only when that counter wraps, which is a common rising edge of every output. The select code and the test clock pass through synchronizers first.

Top module: `clkdiv_tree`

## Requirements
- R1: While rst_n is low, and after reset until a non-zero select code is committed, cpu_clk, pci_clk and apic_clk are low and core_oe, aux_oe and ref_test_sel are 0.
- R2: Select code 000 drives core_oe=0 and aux_oe=0 and holds all three clock outputs low.
- R3: Select code 011 gives cpu_clk = core/2, pci_clk = cpu/2 and apic_clk = pci/2, with core_oe=1, aux_oe=1 and ref_test_sel=0.
- R4: Select code 111 gives cpu_clk = core/2, pci_clk = cpu/3 and apic_clk = pci/2, with core_oe=1, aux_oe=1 and ref_test_sel=0.
- R5: In the running and test modes, every clock output is high for exactly half of each of its periods, including the odd bus ratio.
- R6: Every rising edge of apic_clk coincides with rising edges of pci_clk and cpu_clk, and every rising edge of pci_clk coincides with a rising edge of cpu_clk.
- R7: Select code 100 sets ref_test_sel=1, core_oe=1 and aux_oe=1, and gives cpu_clk = test/2, pci_clk = test/6 and apic_clk = test/12. In every other mode test_clk has no effect on the outputs.
- R8: Select codes 001, 010, 101 and 110 are reserved: core_oe=0, aux_oe=1, ref_test_sel=0, and all three clock outputs stay low.
- R9: A change of select code is committed only when the shared phase counter wraps to zero. No clock output ever produces a high or low pulse shorter than its own half period in the mode it is leaving or entering.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_core | input | 1 | Fast core clock at twice the processor clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| freq_sel | input | 3 | Frequency and mode select code, asynchronous |
| test_clk | input | 1 | External test clock, slower than clk_core/4 |
| cpu_clk | output | 1 | Processor clock |
| pci_clk | output | 1 | Bus clock |
| apic_clk | output | 1 | Interrupt-controller clock (bus/2) |
| core_oe | output | 1 | Enable for the processor, bus and interrupt clock drivers |
| aux_oe | output | 1 | Enable for the reference and USB clock drivers |
| ref_test_sel | output | 1 | Steers the reference driver to test_clk |

## Verification
A new select code passes two synchronizer stages and then waits for the next counter wrap. That is up to 8 or 12 ticks, and in test mode each tick comes three core cycles after a test-clock rise. The outputs are registered on the same edge that commits the code. For each stimulus the bench therefore waits a fixed settling time that is longer than the worst case. It then counts highs and rising edges over a window that holds a whole number of periods of every output. The counts do not depend on the phase at which the window opens. The mode-switch test tracks the length of every high and low run across the switch itself.

// File: rtl/clkdiv_tree_pkg.sv
// Package: shared mode type and select-code decode for the divider tree.
// Assumes a 3-bit select code; the top bit also picks the odd bus ratio.
package clkdiv_tree_pkg;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'd0,
        MODE_RSVD = 2'd1,
        MODE_RUN  = 2'd2,
        MODE_TEST = 2'd3
    } mode_e;

    // Map a raw select code onto the operating mode.
    function automatic mode_e decode_sel(input logic [2:0] code);
        case (code)
            3'b000:         decode_sel = MODE_OFF;
            3'b011, 3'b111: decode_sel = MODE_RUN;
            3'b100:         decode_sel = MODE_TEST;
            default:        decode_sel = MODE_RSVD;
        endcase
    endfunction

endpackage

// File: rtl/clkdiv_sync.sv
// Module: multi-stage flop synchronizer for an asynchronous bus.
// Assumes multi-bit inputs only change when a skew of one cycle between
// bits is harmless, as the commit logic downstream tolerates.
module clkdiv_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] chain;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First stage captures the asynchronous input.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= '0;
                else        chain[g] <= d;
            end
        end else begin : g_next
            // Later stages settle metastability.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= '0;
                else        chain[g] <= chain[g-1];
            end
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/clkdiv_phase_gen.sv
// Module: shared phase counter with commit-at-wrap mode register and
// registered clock outputs. One tick advances the phase by one half
// period of cpu_o. The full counter period is 4*H ticks, where H is the
// bus half period in ticks (LO_HALF or HI_HALF, picked by code bit 2).
// Assumes HI_HALF >= LO_HALF >= 1.
module clkdiv_phase_gen
    import clkdiv_tree_pkg::*;
#(
    parameter int LO_HALF = 2,
    parameter int HI_HALF = 3,
    parameter bit APIC_EN = 1'b1,
    localparam int CNT_W  = $clog2(4 * HI_HALF)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [2:0]       code_req,
    output logic [2:0]       code_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             cpu_o,
    output logic             pci_o,
    output logic             apic_o
);

    localparam logic [CNT_W-1:0] LO_V = CNT_W'(LO_HALF);
    localparam logic [CNT_W-1:0] HI_V = CNT_W'(HI_HALF);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    logic [CNT_W-1:0] h_cur, last_cur, cnt_n, h_n, dh_n, pci_ph;
    logic [2:0]       code_n;
    logic             wrap, run_n, cpu_d, pci_d, apic_d;
    mode_e            mode_n;

    // Next phase, next committed code and next output levels.
    always_comb begin
        h_cur    = code_q[2] ? HI_V : LO_V;
        last_cur = (h_cur << 2) - ONE;
        wrap     = (cnt_q == last_cur);
        cnt_n    = wrap ? '0 : cnt_q + ONE;
        code_n   = wrap ? code_req : code_q;
        mode_n   = decode_sel(code_n);
        run_n    = (mode_n == MODE_RUN) || (mode_n == MODE_TEST);
        h_n      = code_n[2] ? HI_V : LO_V;
        dh_n     = h_n << 1;
        pci_ph   = (cnt_n >= dh_n) ? cnt_n - dh_n : cnt_n;
        cpu_d    = run_n && !cnt_n[0];
        pci_d    = run_n && (pci_ph < h_n);
        apic_d   = APIC_EN && run_n && (cnt_n < dh_n);
    end

    // Advance phase, mode and outputs together on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            code_q <= 3'b000;
            cpu_o  <= 1'b0;
            pci_o  <= 1'b0;
            apic_o <= 1'b0;
        end else if (tick) begin
            cnt_q  <= cnt_n;
            code_q <= code_n;
            cpu_o  <= cpu_d;
            pci_o  <= pci_d;
            apic_o <= apic_d;
        end
    end

endmodule

// File: rtl/clkdiv_tree.sv
// Module: top of the mode-selected divider tree. Synchronizes the select
// code and the test clock, decides the tick source and drives the enables.
// Assumes clk_core runs at twice the processor rate and test_clk is
// slower than clk_core/4 with both phases at least two core cycles long.
module clkdiv_tree
    import clkdiv_tree_pkg::*;
#(
    parameter int SYNC_STAGES   = 2,
    parameter int LO_HALF       = 2,
    parameter int HI_HALF       = 3,
    parameter bit APIC_HALF_PCI = 1'b1
) (
    input  logic       clk_core,
    input  logic       rst_n,
    input  logic [2:0] freq_sel,
    input  logic       test_clk,
    output logic       cpu_clk,
    output logic       pci_clk,
    output logic       apic_clk,
    output logic       core_oe,
    output logic       aux_oe,
    output logic       ref_test_sel
);

    localparam int CNT_W = $clog2(4 * HI_HALF);

    logic [2:0]       sel_s, code_q;
    logic [CNT_W-1:0] cnt_q;
    logic             tck_s, tck_prev, tck_rise, tick;
    mode_e            mode_cur;

    clkdiv_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sel_sync (
        .clk(clk_core), .rst_n(rst_n), .d(freq_sel), .q(sel_s)
    );

    clkdiv_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_tck_sync (
        .clk(clk_core), .rst_n(rst_n), .d(test_clk), .q(tck_s)
    );

    // Remember the last synchronized test-clock level for edge detection.
    always_ff @(posedge clk_core) begin
        if (!rst_n) tck_prev <= 1'b0;
        else        tck_prev <= tck_s;
    end

    // Pick the tick source and decode the enables from the committed mode.
    always_comb begin
        tck_rise     = tck_s && !tck_prev;
        mode_cur     = decode_sel(code_q);
        tick         = (mode_cur == MODE_TEST) ? tck_rise : 1'b1;
        core_oe      = (mode_cur == MODE_RUN) || (mode_cur == MODE_TEST);
        aux_oe       = (mode_cur != MODE_OFF);
        ref_test_sel = (mode_cur == MODE_TEST);
    end

    clkdiv_phase_gen #(
        .LO_HALF(LO_HALF), .HI_HALF(HI_HALF), .APIC_EN(APIC_HALF_PCI)
    ) u_phase (
        .clk(clk_core), .rst_n(rst_n), .tick(tick), .code_req(sel_s),
        .code_q(code_q), .cnt_q(cnt_q),
        .cpu_o(cpu_clk), .pci_o(pci_clk), .apic_o(apic_clk)
    );

endmodule

// File: rtl/clkdiv_tree_chk.sv
// Module: property checker for the divider tree, bound to the top.
// Assumes it sees the committed code and phase counter of the top.
module clkdiv_tree_chk #(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cpu,
    input logic             pci,
    input logic             apic,
    input logic             core_oe,
    input logic             ref_test_sel,
    input logic [2:0]       code_q,
    input logic [CNT_W-1:0] cnt_q
);

    // R2, R8: core drivers off means all core clocks are low.
    p_quiet_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !core_oe |-> (!cpu && !pci && !apic));

    // R6: a bus clock rise is always a processor clock rise too.
    p_pci_aligned_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pci) |-> $rose(cpu));

    // R6: an interrupt clock rise lines up with both others.
    p_apic_aligned_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(apic) |-> ($rose(pci) && $rose(cpu)));

    // R9: the committed code only moves when the counter restarts.
    p_commit_at_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(code_q) |-> (cnt_q == '0));

    // R3: outside test mode the processor clock is high for one core cycle.
    p_cpu_half_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cpu) && !ref_test_sel) |=> $fell(cpu));

    // R7: test steering only happens with the core drivers enabled.
    p_test_enables_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ref_test_sel |-> core_oe);

endmodule

bind clkdiv_tree clkdiv_tree_chk #(.CNT_W($clog2(4 * HI_HALF))) u_chk (
    .clk(clk_core), .rst_n(rst_n), .cpu(cpu_clk), .pci(pci_clk),
    .apic(apic_clk), .core_oe(core_oe), .ref_test_sel(ref_test_sel),
    .code_q(u_phase.code_q), .cnt_q(u_phase.cnt_q)
);

// File: tb/clkdiv_tree_bench.sv
module clkdiv_tree_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] freq_sel = 3'b000;
    logic       test_clk = 1'b0;
    logic       cpu_clk, pci_clk, apic_clk, core_oe, aux_oe, ref_test_sel;
    int         checks = 0;
    int         fails = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;
    always #80 test_clk = ~test_clk;

    clkdiv_tree u_clkdiv_tree (
        .clk_core(clk), .rst_n(rst_n), .freq_sel(freq_sel),
        .test_clk(test_clk), .cpu_clk(cpu_clk), .pci_clk(pci_clk),
        .apic_clk(apic_clk), .core_oe(core_oe), .aux_oe(aux_oe),
        .ref_test_sel(ref_test_sel)
    );

    typedef struct packed {
        logic [2:0]  sel;
        logic [15:0] win;
        logic [7:0]  cr;
        logic [7:0]  pr;
        logic [7:0]  ar;
        logic [15:0] hi;
        logic        coe;
        logic        aoe;
        logic        tsel;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{3'b011, 16'd48,  8'd24, 8'd12, 8'd6, 16'd24, 1'b1, 1'b1, 1'b0},
        '{3'b111, 16'd48,  8'd24, 8'd8,  8'd4, 16'd24, 1'b1, 1'b1, 1'b0},
        '{3'b100, 16'd192, 8'd12, 8'd4,  8'd2, 16'd96, 1'b1, 1'b1, 1'b1},
        '{3'b001, 16'd48,  8'd0,  8'd0,  8'd0, 16'd0,  1'b0, 1'b1, 1'b0},
        '{3'b000, 16'd48,  8'd0,  8'd0,  8'd0, 16'd0,  1'b0, 1'b0, 1'b0},
        '{3'b110, 16'd48,  8'd0,  8'd0,  8'd0, 16'd0,  1'b0, 1'b1, 1'b0},
        '{3'b101, 16'd48,  8'd0,  8'd0,  8'd0, 16'd0,  1'b0, 1'b1, 1'b0},
        '{3'b010, 16'd48,  8'd0,  8'd0,  8'd0, 16'd0,  1'b0, 1'b1, 1'b0},
        '{3'b011, 16'd48,  8'd24, 8'd12, 8'd6, 16'd24, 1'b1, 1'b1, 1'b0}
    };

    task automatic ck(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic string req_of(input logic [2:0] s);
        case (s)
            3'b011:  req_of = "R3";
            3'b111:  req_of = "R4";
            3'b100:  req_of = "R7";
            3'b000:  req_of = "R2";
            default: req_of = "R8";
        endcase
    endfunction

    int cr, pr, ar, ch, ph, ah, abad;

    // Count rises, highs and misaligned rises over a window of samples.
    task automatic measure(input int win);
        logic pc, pp, pa;
        cr = 0; pr = 0; ar = 0; ch = 0; ph = 0; ah = 0; abad = 0;
        @(negedge clk);
        pc = cpu_clk; pp = pci_clk; pa = apic_clk;
        for (int i = 0; i < win; i++) begin
            @(negedge clk);
            if (cpu_clk && !pc)  cr++;
            if (pci_clk && !pp)  pr++;
            if (apic_clk && !pa) ar++;
            if (cpu_clk)  ch++;
            if (pci_clk)  ph++;
            if (apic_clk) ah++;
            if ((apic_clk && !pa) && !((pci_clk && !pp) && (cpu_clk && !pc))) abad++;
            if ((pci_clk && !pp) && !(cpu_clk && !pc)) abad++;
            pc = cpu_clk; pp = pci_clk; pa = apic_clk;
        end
    endtask

    task automatic ck_idle(input string req);
        ck({req, " cpu_clk"}, cpu_clk, 0);
        ck({req, " pci_clk"}, pci_clk, 0);
        ck({req, " apic_clk"}, apic_clk, 0);
        ck({req, " core_oe"}, core_oe, 0);
        ck({req, " aux_oe"}, aux_oe, 0);
        ck({req, " ref_test_sel"}, ref_test_sel, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        string rq;
        int    run_c, run_p, bad_c, bad_p;
        logic  lc, lp;
        // R1: reset state, during and after reset with code 000.
        repeat (4) @(negedge clk);
        ck_idle("R1 in reset");
        rst_n = 1'b1;
        repeat (40) @(negedge clk);
        ck_idle("R1 after reset");

        // Table walk over all modes; test_clk toggles throughout (R7).
        for (int v = 0; v < NV; v++) begin
            freq_sel = VECS[v].sel;
            rq = req_of(VECS[v].sel);
            repeat (250) @(negedge clk);
            ck({rq, " core_oe"}, core_oe, VECS[v].coe);
            ck({rq, " aux_oe"}, aux_oe, VECS[v].aoe);
            ck({rq, " ref_test_sel"}, ref_test_sel, VECS[v].tsel);
            measure(VECS[v].win);
            ck({rq, " cpu rises"}, cr, VECS[v].cr);
            ck({rq, " pci rises"}, pr, VECS[v].pr);
            ck({rq, " apic rises"}, ar, VECS[v].ar);
            ck({rq, " R5 cpu highs"}, ch, VECS[v].hi);
            ck({rq, " R5 pci highs"}, ph, VECS[v].hi);
            ck({rq, " R5 apic highs"}, ah, VECS[v].hi);
            ck("R6 aligned rises", abad, 0);
        end

        // R9: switch 011 -> 111 mid-period; every run must be a legal length.
        repeat (5) @(negedge clk);
        freq_sel = 3'b111;
        bad_c = 0; bad_p = 0; run_c = 0; run_p = 0;
        lc = cpu_clk; lp = pci_clk;
        for (int i = 0; i < 120; i++) begin
            @(negedge clk);
            if (cpu_clk == lc) run_c++;
            else begin
                if (run_c != 0 && run_c != 1) bad_c++;
                run_c = 1;
            end
            if (pci_clk == lp) run_p++;
            else begin
                if (run_p != 0 && i > 4 && run_p != 2 && run_p != 3) bad_p++;
                run_p = 1;
            end
            lc = cpu_clk; lp = pci_clk;
        end
        ck("R9 cpu runs", bad_c, 0);
        ck("R9 pci runs", bad_p, 0);
        measure(48);
        ck("R9 new ratio pci rises", pr, 8);

        // R1: reset applied while running clears the outputs.
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        ck_idle("R1 reset while running");
        rst_n = 1'b1;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule